// File: doc/BRIEF.md
# Interleaved Burst Address Generator

This block sits on the system side of a cache-line read bus. A line is 32 bytes and moves as four quadword transfers of eight bytes each. The bus master drives only the address of the first quadword. The block latches that address when the address strobe is sampled. It then supplies the address of every later transfer itself. It steps to the next transfer only when a ready strobe acknowledges the current one, so any number of wait states can fall between transfers.

The order of the transfers is interleaved, not linear. Transfer k uses the quadword-in-line index (address bits 4:3) equal to the starting index XOR k. The line-aligned upper bits do not change during a burst.

The block also handles early termination. If the cycle turns out not to be cacheable, the first ready strobe ends it as a single transfer. An address strobe that arrives in the same cycle as the ready strobe that ends a burst starts the next burst at once.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and directly after it, `busy_o` is 0, `beat_o` is 0 and `last_o` is 0.
- R2: When `ads_i` is high at a clock edge while the block is idle, the block latches `qaddr_i`. From the next cycle, `busy_o` is 1, `beat_o` is 0 and `qaddr_o` equals the latched address.
- R3: During transfer k (k = 0..3, shown on `beat_o`), `qaddr_o[1:0]` is the starting index XOR k and the upper bits equal the latched upper bits. The resulting orders are: start 0 gives 0,1,2,3; start 1 gives 1,0,3,2; start 2 gives 2,3,0,1; start 3 gives 3,2,1,0.
- R4: While a burst is active and `rdy_i` is low, `beat_o`, `qaddr_o` and `busy_o` hold their values.
- R5: `last_o` is 1 exactly when `busy_o` is 1 and `beat_o` is 3.
- R6: A ready strobe on transfer 3 makes the block idle (`busy_o` = 0, `beat_o` = 0) in the next cycle, unless R10 applies.
- R7: If `cacheable_i` is low together with the ready strobe of transfer 0, the block goes idle in the next cycle and does not step the sequence.
- R8: `cacheable_i` has no effect on the ready strobes of transfers 1 to 3. The burst runs all four transfers.
- R9: An `ads_i` pulse during an active burst that is not on the ending ready strobe is ignored. The address and the sequence continue unchanged.
- R10: If `ads_i` is high in the same cycle as the ready strobe that ends a burst (R6 or R7), a new burst starts in the next cycle, with `beat_o` = 0 and the new address.
- R11: A `rdy_i` pulse while the block is idle has no effect. The block stays idle with `beat_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ads_i | input | 1 | Address strobe from the bus master |
| qaddr_i | input | ADDR_W-3 (29) | Quadword address, byte address bits ADDR_W-1:3 |
| rdy_i | input | 1 | Ready strobe that acknowledges the current transfer |
| cacheable_i | input | 1 | Burst agreement, sampled with the first ready strobe |
| qaddr_o | output | ADDR_W-3 (29) | Quadword address of the current transfer |
| beat_o | output | 2 | Index of the current transfer, 0 to 3 |
| last_o | output | 1 | High during the fourth transfer |
| busy_o | output | 1 | A burst is in progress |

## Verification
Two functions can coincide in one cycle: the ready strobe that ends a burst and the address strobe that opens the next one. The bench provokes this after a full four-transfer burst and again after a burst downgraded on its first ready strobe. In both cases it checks that the following cycle shows transfer 0 at the new address, with no idle cycle in between. It also raises the address strobe in the middle of a burst, where it must leave the running sequence undisturbed.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int QW_LSB = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } bst_state_e;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ads_i,
  input  logic             rdy_i,
  input  logic             cacheable_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] beat_o,
  output logic             last_o,
  output logic             load_o
);

  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BEATS - 1);

  bst_state_e       state_q;
  logic [IDX_W-1:0] beat_q;
  logic             active;
  logic             final_beat;
  logic             downgrade;
  logic             end_xfer;
  logic             load;

  assign active     = (state_q == ST_XFER);
  assign final_beat = (beat_q == LAST_BEAT);
  // burst agreement only matters on the first acknowledge
  assign downgrade  = (beat_q == '0) && !cacheable_i;
  assign end_xfer   = active && rdy_i && (final_beat || downgrade);
  assign load       = ads_i && (!active || end_xfer);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else if (load) begin
      state_q <= ST_XFER;
      beat_q  <= '0;
    end else if (end_xfer) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else if (active && rdy_i) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign busy_o = active;
  assign beat_o = beat_q;
  assign last_o = active && final_beat;
  assign load_o = load;

  p_hold_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rdy_i && !ads_i) |=> ($stable(beat_o) && busy_o));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rdy_i && beat_o != LAST_BEAT && cacheable_i && !ads_i)
      |=> (busy_o && beat_o == $past(beat_o) + 1'b1));

  p_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && rdy_i && !ads_i) |=> (!busy_o && beat_o == '0));

  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_o == '0 && rdy_i && !cacheable_i && !ads_i) |=> !busy_o);

  p_chain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && rdy_i && ads_i) |=> (busy_o && beat_o == '0));

  p_idle_rdy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ads_i) |=> (!busy_o && beat_o == '0));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int QA_W  = 29,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [QA_W-1:0]  qaddr_i,
  input  logic [IDX_W-1:0] beat_i,
  output logic [QA_W-1:0]  qaddr_o
);

  logic [QA_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (load_i) base_q <= qaddr_i;
  end

  // line-aligned part passes through, in-line index is interleaved
  assign qaddr_o[QA_W-1:IDX_W] = base_q[QA_W-1:IDX_W];

  for (genvar b = 0; b < IDX_W; b++) begin : g_xor
    assign qaddr_o[b] = base_q[b] ^ beat_i[b];
  end

  p_upper_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(qaddr_o[QA_W-1:IDX_W]));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4,
  localparam int QA_W  = ADDR_W - QW_LSB,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ads_i,
  input  logic [QA_W-1:0]  qaddr_i,
  input  logic             rdy_i,
  input  logic             cacheable_i,
  output logic [QA_W-1:0]  qaddr_o,
  output logic [IDX_W-1:0] beat_o,
  output logic             last_o,
  output logic             busy_o
);

  logic load;

  burst_seq_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ads_i       (ads_i),
    .rdy_i       (rdy_i),
    .cacheable_i (cacheable_i),
    .busy_o      (busy_o),
    .beat_o      (beat_o),
    .last_o      (last_o),
    .load_o      (load)
  );

  burst_addr_map #(.QA_W(QA_W), .IDX_W(IDX_W)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .qaddr_i (qaddr_i),
    .beat_i  (beat_o),
    .qaddr_o (qaddr_o)
  );

  p_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (busy_o && beat_o == IDX_W'(BEATS - 1)));

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_i && !busy_o) |=> (busy_o && beat_o == '0 && qaddr_o == $past(qaddr_i)));

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int QA_W = 29;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ads_i = 1'b0;
  logic [QA_W-1:0] qaddr_i = '0;
  logic            rdy_i = 1'b0;
  logic            cacheable_i = 1'b1;
  logic [QA_W-1:0] qaddr_o;
  logic [1:0]      beat_o;
  logic            last_o;
  logic            busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_gen uut (
    .clk_i, .rst_ni, .ads_i, .qaddr_i, .rdy_i, .cacheable_i,
    .qaddr_o, .beat_o, .last_o, .busy_o
  );

  // {start[11:10], order[9:2] first transfer highest, wait states[1:0]}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 8'b00_01_10_11, 2'd0},
    {2'd1, 8'b01_00_11_10, 2'd0},
    {2'd2, 8'b10_11_00_01, 2'd0},
    {2'd3, 8'b11_10_01_00, 2'd0},
    {2'd0, 8'b00_01_10_11, 2'd2},
    {2'd1, 8'b01_00_11_10, 2'd1},
    {2'd2, 8'b10_11_00_01, 2'd3},
    {2'd3, 8'b11_10_01_00, 2'd2}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic beat_chk(string tag, logic [QA_W-1:0] ea, int k);
    check({tag, " addr"}, 64'(qaddr_o), 64'(ea));
    check({tag, " beat"}, 64'(beat_o), 64'(k));
    check({tag, " last R5"}, 64'(last_o), 64'(k == 3));
    check({tag, " busy"}, 64'(busy_o), 64'd1);
  endtask

  function automatic logic [QA_W-1:0] mk(logic [26:0] up, logic [1:0] q);
    return {up, q};
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [26:0] up;
    @(negedge clk_i);
    check("R1 busy in reset", 64'(busy_o), 0);
    check("R1 beat in reset", 64'(beat_o), 0);
    step();
    rst_ni = 1'b1;
    step();
    check("R1 busy after reset", 64'(busy_o), 0);
    check("R1 last after reset", 64'(last_o), 0);

    // vector walk: R2 R3 R4 R6
    foreach (VEC[i]) begin
      up = 27'h0ABC_D00 + 27'(i * 3);
      qaddr_i = mk(up, VEC[i][11:10]);
      ads_i = 1'b1;
      step();
      ads_i = 1'b0;
      qaddr_i = '0;
      check("R2 start addr", 64'(qaddr_o), 64'(mk(up, VEC[i][11:10])));
      for (int k = 0; k < 4; k++) begin
        for (int w = 0; w < int'(VEC[i][1:0]); w++) begin
          beat_chk("R4 wait", mk(up, VEC[i][9-2*k -: 2]), k);
          step();
        end
        beat_chk("R3 order", mk(up, VEC[i][9-2*k -: 2]), k);
        rdy_i = 1'b1;
        step();
        rdy_i = 1'b0;
      end
      check("R6 idle after last", 64'(busy_o), 0);
      check("R6 beat cleared", 64'(beat_o), 0);
    end

    // R11: ready while idle
    rdy_i = 1'b1;
    step();
    rdy_i = 1'b0;
    check("R11 idle rdy busy", 64'(busy_o), 0);
    check("R11 idle rdy beat", 64'(beat_o), 0);

    // R7: downgrade on first ready
    up = 27'h1234567;
    qaddr_i = mk(up, 2'd2);
    ads_i = 1'b1;
    step();
    ads_i = 1'b0;
    beat_chk("R7 first", mk(up, 2'd2), 0);
    cacheable_i = 1'b0;
    rdy_i = 1'b1;
    step();
    rdy_i = 1'b0;
    cacheable_i = 1'b1;
    check("R7 single ends", 64'(busy_o), 0);
    check("R7 no step", 64'(beat_o), 0);

    // R8 and R9: cacheable low on later beats, ads mid-burst
    up = 27'h0F0F0F0;
    qaddr_i = mk(up, 2'd1);
    ads_i = 1'b1;
    step();
    ads_i = 1'b0;
    rdy_i = 1'b1;
    step();
    rdy_i = 1'b0;
    cacheable_i = 1'b0;
    qaddr_i = mk(27'h7777777, 2'd3);
    ads_i = 1'b1;
    step();
    ads_i = 1'b0;
    beat_chk("R9 ads ignored", mk(up, 2'd0), 1);
    for (int k = 1; k < 4; k++) begin
      beat_chk("R8 later beats", mk(up, 2'(1 ^ k)), k);
      rdy_i = 1'b1;
      step();
      rdy_i = 1'b0;
    end
    cacheable_i = 1'b1;
    check("R8 full burst ends", 64'(busy_o), 0);

    // R10: ads with final ready, then ads with downgrade ready
    up = 27'h0000F00;
    qaddr_i = mk(up, 2'd3);
    ads_i = 1'b1;
    step();
    ads_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rdy_i = 1'b1;
      if (k == 3) begin
        ads_i = 1'b1;
        qaddr_i = mk(27'h5A5A5A5, 2'd1);
      end
      step();
      rdy_i = 1'b0;
      ads_i = 1'b0;
    end
    beat_chk("R10 chained", mk(27'h5A5A5A5, 2'd1), 0);
    cacheable_i = 1'b0;
    rdy_i = 1'b1;
    ads_i = 1'b1;
    qaddr_i = mk(27'h2222222, 2'd2);
    step();
    cacheable_i = 1'b1;
    rdy_i = 1'b0;
    ads_i = 1'b0;
    beat_chk("R10 after single", mk(27'h2222222, 2'd2), 0);
    rdy_i = 1'b1;
    step();
    beat_chk("R10 step", mk(27'h2222222, 2'd3), 1);
    rdy_i = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule